// File: doc/BRIEF.md
# Partial-Write Read-Modify-Write Merger

This block takes write requests from a host and turns them into writes to a memory port that stores a 64-bit double word together with an 8-bit SEC-DED check byte. When a request sets all eight byte enables, the block writes the host data straight through with a freshly generated check byte. When a request sets fewer than eight byte enables, the block first reads the whole double word at the same address. It checks that word, corrects it if one bit is wrong, replaces the enabled bytes with the host bytes, regenerates the check byte and writes the full word back.

If the read word holds an uncorrectable error, the block still runs the whole sequence to the end so that the controller never stalls. The final write then goes out with every byte strobe cleared, so the stored contents stay as they were. The host acknowledge carries an error flag in that case. Two one-cycle pulses, one for corrected errors and one for uncorrectable errors, feed an external error-reporting block. The block handles one transaction at a time.

Top module: `rmw_merge_unit`

## Requirements
- R1: A request with all eight byte enables set causes no read. In the cycle after acceptance the block issues one write with all strobes set, the host data, and the check byte of that data. `req_ack` is high in the cycle after that, with `ack_err` low.
- R2: A request with any byte enable clear first issues a one-cycle read at the request address, in the cycle after acceptance. No write starts before the read data returns.
- R3: If the returned word and check byte differ from a valid codeword in exactly one bit, the data is corrected before the merge. `sbe_pulse` is high for one cycle, in the write cycle, and `mbe_pulse` stays low.
- R4: The write-back word takes byte b (bits 8b+7..8b) from the host when `req_be[b]` is 1 and from the corrected read word otherwise. On a correctable or clean read all eight strobes are set.
- R5: The check byte is computed as follows. Data bits 0..63 go, in ascending order, to the codeword positions 1..71 that are not powers of two. Check bit c (c = 0..6) is the XOR of the data bits whose position has bit c set. Check bit 7 is the XOR of all data bits and of check bits 0..6.
- R6: If the read shows two flipped bits (an uncorrectable error), the write cycle still occurs, but with `mem_wr_strb` all zero. `mbe_pulse` is high in that cycle, and the acknowledge that follows has `ack_err` high.
- R7: `ack_err` is high only together with `req_ack`, and only after a masked write.
- R8: Reads and writes never overlap. A held request is not taken again until its acknowledge has been given.
- R9: During and after reset, before any request, every request and acknowledge output is low.
- R10: A single flipped bit in the check byte itself leaves the data unchanged and counts as a corrected error, raising `sbe_pulse`.
- R11: A request with no byte enable set reads the word and writes back the corrected word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host write request, held until acknowledged |
| req_addr | input | 32 | Double-word address |
| req_data | input | 64 | Host write data |
| req_be | input | 8 | Byte enables, bit b selects data byte b |
| req_ack | output | 1 | One-cycle completion pulse |
| ack_err | output | 1 | Completion ended with a masked write |
| mem_rd_req | output | 1 | One-cycle memory read command |
| mem_wr_req | output | 1 | One-cycle memory write command |
| mem_addr | output | 32 | Address for both commands |
| mem_wr_data | output | 64 | Write data |
| mem_wr_chk | output | 8 | Write check byte |
| mem_wr_strb | output | 8 | Byte strobes; all zero means nothing is stored |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Read data |
| mem_rd_chk | input | 8 | Read check byte |
| sbe_pulse | output | 1 | Corrected error seen |
| mbe_pulse | output | 1 | Uncorrectable error seen |

## Verification
The properties assume a well-behaved host and memory. The host keeps `req_valid` and its fields steady until `req_ack` and drops them in the cycle after it. The memory raises `mem_rd_valid` for exactly one cycle, only while a read is outstanding. The bench holds to both rules. Its memory model answers each read after a chosen delay of zero or more cycles with a one-cycle valid, and it flips at most two codeword bits per read.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WAIT,
      ST_MERGE,
      ST_WRITE,
      ST_DONE
   } rmw_state_e;

   // number of Hamming bits needed to cover dw data bits
   function automatic int ham_bits(input int dw);
      for (int k = 1; k < 16; k++) begin
         if ((1 << k) >= dw + k + 1) return k;
      end
      return 16;
   endfunction

   // codeword position of data bit idx (non-powers of two from 3 upward)
   function automatic int data_pos(input int idx);
      int cnt;
      cnt = 0;
      for (int p = 3; p < 1024; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (cnt == idx) return p;
            cnt++;
         end
      end
      return 0;
   endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
   parameter int DATA_W = 64,
   localparam int HAM_W = rmw_pkg::ham_bits(DATA_W),
   localparam int CHK_W = HAM_W + 1
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);

   function automatic logic [DATA_W-1:0] col_mask(input int c);
      logic [DATA_W-1:0] m;
      for (int d = 0; d < DATA_W; d++) begin
         m[d] = ((rmw_pkg::data_pos(d) >> c) & 1) == 1;
      end
      return m;
   endfunction

   logic [HAM_W-1:0] ham;

   for (genvar c = 0; c < HAM_W; c++) begin : g_col
      localparam logic [DATA_W-1:0] MASK = col_mask(c);
      assign ham[c] = ^(data & MASK);
   end

   assign chk = {(^data) ^ (^ham), ham};

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
   parameter int DATA_W = 64,
   localparam int HAM_W = rmw_pkg::ham_bits(DATA_W),
   localparam int CHK_W = HAM_W + 1
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic [CHK_W-1:0]  chk_in,
   output logic [DATA_W-1:0] data_out,
   output logic              single_err,
   output logic              multi_err
);

   logic [CHK_W-1:0] recomp;
   logic [HAM_W-1:0] syn;
   logic             par;
   logic             out_of_range;
   logic             fix_en;

   secded_enc #(.DATA_W(DATA_W)) u_reenc (
      .data (data_in),
      .chk  (recomp)
   );

   assign syn          = recomp[HAM_W-1:0] ^ chk_in[HAM_W-1:0];
   assign par          = recomp[HAM_W] ^ chk_in[HAM_W] ^ (^syn);
   assign out_of_range = int'(syn) > (DATA_W + HAM_W);
   assign fix_en       = par && !out_of_range;
   assign single_err   = fix_en;
   assign multi_err    = (!par && (syn != '0)) || (par && out_of_range);

   for (genvar d = 0; d < DATA_W; d++) begin : g_fix
      localparam int POS = rmw_pkg::data_pos(d);
      assign data_out[d] = data_in[d] ^ (fix_en && (syn == HAM_W'(POS)));
   end

endmodule

// File: rtl/rmw_byte_merge.sv
module rmw_byte_merge #(
   parameter int DATA_W = 64,
   localparam int BYTES = DATA_W / 8
) (
   input  logic [DATA_W-1:0] old_data,
   input  logic [DATA_W-1:0] new_data,
   input  logic [BYTES-1:0]  be,
   output logic [DATA_W-1:0] merged
);

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign merged[b*8 +: 8] = be[b] ? new_data[b*8 +: 8] : old_data[b*8 +: 8];
   end

endmodule

// File: rtl/rmw_merge_unit.sv
module rmw_merge_unit #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int CHK_W = rmw_pkg::ham_bits(DATA_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [BYTES-1:0]  req_be,
   output logic              req_ack,
   output logic              ack_err,
   output logic              mem_rd_req,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic [CHK_W-1:0]  mem_wr_chk,
   output logic [BYTES-1:0]  mem_wr_strb,
   input  logic              mem_rd_valid,
   input  logic [DATA_W-1:0] mem_rd_data,
   input  logic [CHK_W-1:0]  mem_rd_chk,
   output logic              sbe_pulse,
   output logic              mbe_pulse
);
   import rmw_pkg::*;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (DATA_W < 8 || DATA_W > 512) begin : g_bad_range
      $error("DATA_W must lie between 8 and 512");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end

   rmw_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] host_q;
   logic [BYTES-1:0]  be_q;
   logic [DATA_W-1:0] rd_data_q;
   logic [CHK_W-1:0]  rd_chk_q;
   logic [DATA_W-1:0] wdata_q;
   logic              mask_q;
   logic              sbe_q;
   logic              mbe_q;

   logic [DATA_W-1:0] fixed_data;
   logic              dec_single;
   logic              dec_multi;
   logic [DATA_W-1:0] merged;

   secded_dec #(.DATA_W(DATA_W)) u_dec (
      .data_in    (rd_data_q),
      .chk_in     (rd_chk_q),
      .data_out   (fixed_data),
      .single_err (dec_single),
      .multi_err  (dec_multi)
   );

   rmw_byte_merge #(.DATA_W(DATA_W)) u_merge (
      .old_data (fixed_data),
      .new_data (host_q),
      .be       (be_q),
      .merged   (merged)
   );

   secded_enc #(.DATA_W(DATA_W)) u_enc (
      .data (wdata_q),
      .chk  (mem_wr_chk)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         addr_q    <= '0;
         host_q    <= '0;
         be_q      <= '0;
         rd_data_q <= '0;
         rd_chk_q  <= '0;
         wdata_q   <= '0;
         mask_q    <= 1'b0;
         sbe_q     <= 1'b0;
         mbe_q     <= 1'b0;
      end else begin
         sbe_q <= 1'b0;
         mbe_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q <= req_addr;
                  host_q <= req_data;
                  be_q   <= req_be;
                  mask_q <= 1'b0;
                  if (&req_be) begin
                     wdata_q <= req_data;
                     state   <= ST_WRITE;
                  end else begin
                     state   <= ST_READ;
                  end
               end
            end
            ST_READ: state <= ST_WAIT;
            ST_WAIT: begin
               if (mem_rd_valid) begin
                  rd_data_q <= mem_rd_data;
                  rd_chk_q  <= mem_rd_chk;
                  state     <= ST_MERGE;
               end
            end
            ST_MERGE: begin
               wdata_q <= merged;
               mask_q  <= dec_multi;
               sbe_q   <= dec_single;
               mbe_q   <= dec_multi;
               state   <= ST_WRITE;
            end
            ST_WRITE: state <= ST_DONE;
            ST_DONE:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd_req  = (state == ST_READ);
   assign mem_wr_req  = (state == ST_WRITE);
   assign mem_addr    = addr_q;
   assign mem_wr_data = wdata_q;
   assign mem_wr_strb = mask_q ? '0 : '1;
   assign req_ack     = (state == ST_DONE);
   assign ack_err     = (state == ST_DONE) && mask_q;
   assign sbe_pulse   = sbe_q;
   assign mbe_pulse   = mbe_q;

endmodule

// File: rtl/rmw_merge_unit_chk.sv
module rmw_merge_unit_chk #(
   parameter int DATA_W = 64,
   localparam int BYTES = DATA_W / 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ack,
   input logic             ack_err,
   input logic             mem_rd_req,
   input logic             mem_wr_req,
   input logic [BYTES-1:0] mem_wr_strb,
   input logic             sbe_pulse,
   input logic             mbe_pulse
);

   AST_NO_DUAL_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_req && mem_wr_req)); // R8

   AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req); // R2

   AST_STRB_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> (mem_wr_strb == '1 || mem_wr_strb == '0)); // R4

   AST_MASK_NEEDS_MBE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && mem_wr_strb == '0) |-> mbe_pulse); // R6

   AST_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> $past(mem_wr_req)); // R1

   AST_ACK_ERR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> (ack_err == $past(mbe_pulse))); // R7

   AST_ERR_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ack_err |-> req_ack); // R7

   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(sbe_pulse && mbe_pulse)); // R3

   AST_PULSE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (sbe_pulse || mbe_pulse) |-> mem_wr_req); // R10

endmodule

bind rmw_merge_unit rmw_merge_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ack     (req_ack),
   .ack_err     (ack_err),
   .mem_rd_req  (mem_rd_req),
   .mem_wr_req  (mem_wr_req),
   .mem_wr_strb (mem_wr_strb),
   .sbe_pulse   (sbe_pulse),
   .mbe_pulse   (mbe_pulse)
);

// File: tb/tb_rmw_merge_unit.sv
module tb_rmw_merge_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [63:0] req_data = '0;
   logic [7:0]  req_be = '0;
   logic        req_ack, ack_err, mem_rd_req, mem_wr_req;
   logic [31:0] mem_addr;
   logic [63:0] mem_wr_data;
   logic [7:0]  mem_wr_chk, mem_wr_strb;
   logic        mem_rd_valid = 1'b0;
   logic [63:0] mem_rd_data = '0;
   logic [7:0]  mem_rd_chk = '0;
   logic        sbe_pulse, mbe_pulse;

   int n_chk = 0;
   int n_fail = 0;
   logic [63:0] model_mem [logic [31:0]];

   always #2.5 clk = ~clk;

   rmw_merge_unit dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_data(req_data), .req_be(req_be), .req_ack(req_ack), .ack_err(ack_err),
      .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
      .mem_wr_data(mem_wr_data), .mem_wr_chk(mem_wr_chk), .mem_wr_strb(mem_wr_strb),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .mem_rd_chk(mem_rd_chk),
      .sbe_pulse(sbe_pulse), .mbe_pulse(mbe_pulse)
   );

   // behavioural SEC-DED code built from an explicit codeword array
   function automatic logic [7:0] ref_ecc(input logic [63:0] d);
      logic [71:0] cw;
      logic [7:0]  r;
      int k;
      cw = '0;
      r  = '0;
      k  = 0;
      for (int p = 1; p <= 71; p++) begin
         if ((p & (p - 1)) != 0) begin
            cw[p] = d[k];
            k++;
         end
      end
      for (int c = 0; c < 7; c++)
         for (int p = 1; p <= 71; p++)
            if (p[c]) r[c] = r[c] ^ cw[p];
      r[7] = (^d) ^ (^r[6:0]);
      return r;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one cycle of control outputs against expectation
   task automatic cmp_ctl(input string tag, input logic e_rd, input logic e_wr,
                          input logic e_ack, input logic e_err,
                          input logic e_sbe, input logic e_mbe);
      check(tag, "mem_rd_req", 64'(mem_rd_req), 64'(e_rd));
      check(tag, "mem_wr_req", 64'(mem_wr_req), 64'(e_wr));
      check(tag, "req_ack",    64'(req_ack),    64'(e_ack));
      check(tag, "ack_err",    64'(ack_err),    64'(e_err));
      check(tag, "sbe_pulse",  64'(sbe_pulse),  64'(e_sbe));
      check(tag, "mbe_pulse",  64'(mbe_pulse),  64'(e_mbe));
   endtask

   task automatic txn(input string tag, input logic [31:0] a, input logic [63:0] d,
                      input logic [7:0] be, input logic [63:0] flip_d,
                      input logic [7:0] flip_c, input int lat);
      logic [63:0] old, exp_w;
      int nflip;
      logic e_sbe, e_mbe;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_data = d; req_be = be;
      @(negedge clk);
      if (&be) begin
         cmp_ctl(tag, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
         check(tag, "wr_addr", 64'(mem_addr), 64'(a));
         check(tag, "wr_data", mem_wr_data, d);
         check(tag, "wr_chk",  64'(mem_wr_chk), 64'(ref_ecc(d)));
         check(tag, "wr_strb", 64'(mem_wr_strb), 64'hFF);
         model_mem[a] = d;
         @(negedge clk);
         cmp_ctl(tag, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      end else begin
         old = model_mem.exists(a) ? model_mem[a] : 64'h0;
         cmp_ctl(tag, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
         check(tag, "rd_addr", 64'(mem_addr), 64'(a));
         for (int i = 0; i <= lat; i++) begin
            @(negedge clk);
            cmp_ctl(tag, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
         end
         mem_rd_valid = 1'b1;
         mem_rd_data  = old ^ flip_d;
         mem_rd_chk   = ref_ecc(old) ^ flip_c;
         @(negedge clk);
         mem_rd_valid = 1'b0;
         cmp_ctl(tag, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
         nflip = $countones(flip_d) + $countones(flip_c);
         e_sbe = (nflip == 1);
         e_mbe = (nflip == 2);
         for (int b = 0; b < 8; b++) exp_w[b*8 +: 8] = be[b] ? d[b*8 +: 8] : old[b*8 +: 8];
         @(negedge clk);
         cmp_ctl(tag, 1'b0, 1'b1, 1'b0, 1'b0, e_sbe, e_mbe);
         check(tag, "wr_addr", 64'(mem_addr), 64'(a));
         if (e_mbe) begin
            check(tag, "wr_strb masked", 64'(mem_wr_strb), 64'h00);
         end else begin
            check(tag, "wr_data", mem_wr_data, exp_w);
            check(tag, "wr_chk",  64'(mem_wr_chk), 64'(ref_ecc(exp_w)));
            check(tag, "wr_strb", 64'(mem_wr_strb), 64'hFF);
            model_mem[a] = exp_w;
         end
         @(negedge clk);
         cmp_ctl(tag, 1'b0, 1'b0, 1'b1, e_mbe, 1'b0, 1'b0);
      end
      req_valid = 1'b0;
      @(negedge clk);
      cmp_ctl("R8", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      cmp_ctl("R9", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_ctl("R9", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R1: full writes, several patterns
      txn("R1", 32'h100, 64'h0123_4567_89AB_CDEF, 8'hFF, '0, '0, 0);
      txn("R1", 32'h108, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, '0, '0, 0);
      txn("R1", 32'h110, 64'h0, 8'hFF, '0, '0, 0);
      txn("R5", 32'h118, 64'hA5A5_5A5A_C3C3_3C3C, 8'hFF, '0, '0, 0);
      // R2 / R4: clean partial writes with varying latency and enables
      txn("R2", 32'h100, 64'hDEAD_BEEF_CAFE_F00D, 8'h0F, '0, '0, 0);
      txn("R4", 32'h108, 64'h1111_2222_3333_4444, 8'h81, '0, '0, 3);
      txn("R4", 32'h110, 64'h5566_7788_99AA_BBCC, 8'h5A, '0, '0, 1);
      // R3: single data bit flip corrected
      txn("R3", 32'h118, 64'h0000_0000_0000_00EE, 8'h01, 64'h1 << 37, '0, 2);
      txn("R3", 32'h100, 64'h7700_0000_0000_0000, 8'h80, 64'h1, '0, 0);
      // R10: check byte bit flips (Hamming bit and overall bit)
      txn("R10", 32'h108, 64'h0000_0000_00AB_0000, 8'h04, '0, 8'h04, 1);
      txn("R10", 32'h110, 64'h0000_CD00_0000_0000, 8'h20, '0, 8'h80, 0);
      // R6: double flip masks the write, memory keeps old word
      txn("R6", 32'h118, 64'h9999_9999_9999_9999, 8'h3C, (64'h1 << 60) | 64'h20, '0, 1);
      txn("R6", 32'h118, 64'h0, 8'h00, '0, '0, 0);
      // R11: no enables -> corrected word written back unchanged
      txn("R11", 32'h100, 64'hFFFF_0000_FFFF_0000, 8'h00, 64'h1 << 12, '0, 0);
      // R7: clean partial after error shows no error flag
      txn("R7", 32'h108, 64'h0BAD_0BAD_0BAD_0BAD, 8'hF0, '0, '0, 0);

      summary();
      $finish;
   end

endmodule